// File: doc/BRIEF.md
# Multi-Stop Interpolating Time-Interval Core

This block is the digital back end of a time-to-digital converter. One START event opens a single-shot measurement. Up to three STOP pulses that follow are each measured for position and width. A free-running coarse counter on the fast internal clock gives the whole-period part of every time stamp. External middle and fine delay stages supply already-decoded interpolation codes for the START edge and for every STOP edge. The codes give how far each edge lies before the clock edge that samples it.

Each STOP edge is reported as a three-level value: the coarse count in units of the clock period, plus the START residue, minus the edge residue. The position of a pulse is the value of its rising edge. Its width is the falling value minus the rising value. The width is kept so that a later stage can correct amplitude-dependent walk.

One record per channel holds three positions, three widths, a per-pulse valid bit and a timeout flag. It is offered on a valid/ready handshake and held until it is taken.

Top module: `tdc_multistop_core`

## Requirements
- R1: After reset, `res_valid` and `res_timeout` are 0.
- R2: A residue is `mid*2^FINE_W + fine`, which is `{mid,fine}`. With the default widths a middle step is 4 fine LSBs and one clock period is 32 LSBs. A rising strobe sampled K clock edges after the edge that accepted START gives position = K*2^(MID_W+FINE_W) + start residue − rise residue. K runs from 1 to 2^CNT_W−1.
- R3: Width = (Kfall−Krise)*2^(MID_W+FINE_W) + rise residue − fall residue, modulo 2^TW.
- R4: Pulses fill slots 0, 1, 2 in arrival order; slot i sits at bits [i*TW +: TW]. On the edge that samples the third falling strobe, `res_valid` rises with `res_ok`=all ones and `res_timeout`=0.
- R5: A rising strobe is ignored while a falling edge is awaited, and a falling strobe is ignored while a rising edge is awaited. If both strobes arrive in the same cycle while a rise is awaited, only the rise is taken.
- R6: If the coarse count reaches 2^CNT_W−1 before the measurement completes, `res_valid` rises on that edge with `res_timeout`=1. Strobes on that same edge are still captured, and a completion on that edge gives `res_timeout`=0.
- R7: Every slot whose pulse did not complete reads `res_ok[i]`=0 and has zero position and zero width.
- R8: While `res_valid` is high and `res_ready` is low, all result outputs stay constant. The cycle after `res_valid && res_ready`, `res_valid` is 0.
- R9: A START strobe during a measurement is ignored. Stamps stay relative to the first START.
- R10: A START strobe is ignored while a result is pending, including the cycle in which the result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_stb | input | 1 | START edge strobe |
| start_mid | input | MID_W | START middle interpolation code |
| start_fine | input | FINE_W | START fine interpolation code |
| rise_stb | input | 1 | STOP rising edge strobe |
| rise_mid | input | MID_W | Rising edge middle code |
| rise_fine | input | FINE_W | Rising edge fine code |
| fall_stb | input | 1 | STOP falling edge strobe |
| fall_mid | input | MID_W | Falling edge middle code |
| fall_fine | input | FINE_W | Falling edge fine code |
| res_valid | output | 1 | Result record available |
| res_ready | input | 1 | Consumer takes the record |
| res_pos | output | N_STOP*TW | Pulse positions, slot i at [i*TW +: TW] |
| res_width | output | N_STOP*TW | Pulse widths, same packing |
| res_ok | output | N_STOP | Per-pulse complete flags |
| res_timeout | output | 1 | Measurement ended at full count |

## Verification
The bench builds the core with an 8-bit coarse counter, 3-bit middle and 2-bit fine codes, and three STOP slots. With these values full range is only 255 periods. Within a short run this reaches the timeout path and a completion exactly on the last count, next to interpolation codes at both extremes. The 13-bit timestamp keeps the modulo arithmetic of positions and widths in plain view.

// File: rtl/tdc_ms_pkg.sv
// Shared types for the multi-stop time-interval core.
// Assumes: nothing beyond IEEE 1800-2017.
package tdc_ms_pkg;
    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_MEAS = 2'd1,
        TS_DONE = 2'd2
    } tdc_state_e;
endpackage

// File: rtl/tdc_ms_coarse.sv
// Coarse period counter. On clear it loads 1, so the first edge after the
// START edge reads 1. It counts while run is high and saturates at all ones.
// Assumes: clear and run are never needed in the same cycle.
module tdc_ms_coarse #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // counter register: load on clear, advance while running below full range
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= CNT_W'(1);
        else if (run && !at_max)
            cnt <= cnt + CNT_W'(1);
    end

    assign at_max = (cnt == CNT_MAX);
endmodule

// File: rtl/tdc_ms_stamp.sv
// Three-level time stamp: coarse periods in LSBs, plus the START residue,
// minus the edge residue. One period spans 2^(MID_W+FINE_W) LSBs, and one
// middle step equals 2^FINE_W fine steps.
// Assumes: coarse >= 1, so the result never underflows.
module tdc_ms_stamp #(
    parameter int CNT_W  = 13,
    parameter int MID_W  = 3,
    parameter int FINE_W = 2,
    localparam int RES_W = MID_W + FINE_W,
    localparam int TW    = CNT_W + RES_W
) (
    input  logic [CNT_W-1:0]  coarse,
    input  logic [RES_W-1:0]  start_res,
    input  logic [MID_W-1:0]  edge_mid,
    input  logic [FINE_W-1:0] edge_fine,
    output logic [TW-1:0]     stamp
);
    logic [RES_W-1:0] edge_res;

    // merge the two interpolation levels into one residue in fine LSBs
    assign edge_res = {edge_mid, edge_fine};

    // coarse periods plus start residue minus edge residue
    assign stamp = {coarse, RES_W'(0)} + TW'(start_res) - TW'(edge_res);
endmodule

// File: rtl/tdc_ms_slot.sv
// Storage for one STOP pulse: its position, its width and a done flag.
// Clear zeroes everything; commit loads both values and sets the flag.
// Assumes: clear and commit never coincide.
module tdc_ms_slot #(
    parameter int TW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          commit,
    input  logic [TW-1:0] pos_in,
    input  logic [TW-1:0] width_in,
    output logic [TW-1:0] pos,
    output logic [TW-1:0] width,
    output logic          ok
);
    // slot register: zero on reset or clear, capture on commit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos   <= '0;
            width <= '0;
            ok    <= 1'b0;
        end else if (commit) begin
            pos   <= pos_in;
            width <= width_in;
            ok    <= 1'b1;
        end
    end
endmodule

// File: rtl/tdc_multistop_core.sv
// Single-shot multi-stop time-interval core. A START accepted in idle opens
// a measurement. STOP rising and falling strobes alternate into N_STOP slots.
// The record closes on the last falling edge or at full coarse count, and is
// held on a valid/ready handshake.
// Assumes: strobes arrive one clock after their edge, with decoded codes.
module tdc_multistop_core #(
    parameter int CNT_W  = 13,
    parameter int MID_W  = 3,
    parameter int FINE_W = 2,
    parameter int N_STOP = 3,
    localparam int RES_W = MID_W + FINE_W,
    localparam int TW    = CNT_W + RES_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_stb,
    input  logic [MID_W-1:0]     start_mid,
    input  logic [FINE_W-1:0]    start_fine,
    input  logic                 rise_stb,
    input  logic [MID_W-1:0]     rise_mid,
    input  logic [FINE_W-1:0]    rise_fine,
    input  logic                 fall_stb,
    input  logic [MID_W-1:0]     fall_mid,
    input  logic [FINE_W-1:0]    fall_fine,
    output logic                 res_valid,
    input  logic                 res_ready,
    output logic [N_STOP*TW-1:0] res_pos,
    output logic [N_STOP*TW-1:0] res_width,
    output logic [N_STOP-1:0]    res_ok,
    output logic                 res_timeout
);
    import tdc_ms_pkg::*;

    localparam int IDX_W = (N_STOP > 1) ? $clog2(N_STOP) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_STOP - 1);

    tdc_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             wait_fall;
    logic [RES_W-1:0] s_res_q;
    logic [TW-1:0]    rise_t_q;
    logic             timeout_q;
    logic [CNT_W-1:0] cnt;
    logic             at_max;
    logic [TW-1:0]    rise_t;
    logic [TW-1:0]    fall_t;
    logic [TW-1:0]    width_t;
    logic             start_acc;
    logic             rise_acc;
    logic             fall_acc;
    logic             last_fall;

    // qualify the strobes by state and by which edge is awaited
    assign start_acc = (state == TS_IDLE) && start_stb;
    assign rise_acc  = (state == TS_MEAS) && !wait_fall && rise_stb;
    assign fall_acc  = (state == TS_MEAS) && wait_fall && fall_stb;
    assign last_fall = fall_acc && (idx == IDX_LAST);

    // measurement sequence: idle, measure, hold the record until accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TS_IDLE;
            timeout_q <= 1'b0;
        end else begin
            case (state)
                TS_IDLE: if (start_acc) begin
                    state     <= TS_MEAS;
                    timeout_q <= 1'b0;
                end
                TS_MEAS: if (last_fall) begin
                    state <= TS_DONE;
                end else if (at_max) begin
                    state     <= TS_DONE;
                    timeout_q <= 1'b1;
                end
                TS_DONE: if (res_ready) state <= TS_IDLE;
                default: state <= TS_IDLE;
            endcase
        end
    end

    // edge tracker: start residue, awaited edge, slot index, pending rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            wait_fall <= 1'b0;
            s_res_q   <= '0;
            rise_t_q  <= '0;
        end else if (start_acc) begin
            idx       <= '0;
            wait_fall <= 1'b0;
            s_res_q   <= {start_mid, start_fine};
        end else if (rise_acc) begin
            wait_fall <= 1'b1;
            rise_t_q  <= rise_t;
        end else if (fall_acc) begin
            wait_fall <= 1'b0;
            if (!last_fall) idx <= idx + IDX_W'(1);
        end
    end

    tdc_ms_coarse #(.CNT_W(CNT_W)) u_coarse (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_acc),
        .run    (state == TS_MEAS),
        .cnt    (cnt),
        .at_max (at_max)
    );

    tdc_ms_stamp #(.CNT_W(CNT_W), .MID_W(MID_W), .FINE_W(FINE_W)) u_rise_stamp (
        .coarse    (cnt),
        .start_res (s_res_q),
        .edge_mid  (rise_mid),
        .edge_fine (rise_fine),
        .stamp     (rise_t)
    );

    tdc_ms_stamp #(.CNT_W(CNT_W), .MID_W(MID_W), .FINE_W(FINE_W)) u_fall_stamp (
        .coarse    (cnt),
        .start_res (s_res_q),
        .edge_mid  (fall_mid),
        .edge_fine (fall_fine),
        .stamp     (fall_t)
    );

    // pulse width: falling stamp minus the stored rising stamp, modulo 2^TW
    assign width_t = fall_t - rise_t_q;

    for (genvar i = 0; i < N_STOP; i++) begin : g_slot
        logic [TW-1:0] slot_pos;
        logic [TW-1:0] slot_wid;
        logic          slot_ok;

        tdc_ms_slot #(.TW(TW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (start_acc),
            .commit   (fall_acc && (idx == IDX_W'(i))),
            .pos_in   (rise_t_q),
            .width_in (width_t),
            .pos      (slot_pos),
            .width    (slot_wid),
            .ok       (slot_ok)
        );

        assign res_pos[i*TW +: TW]   = slot_pos;
        assign res_width[i*TW +: TW] = slot_wid;
        assign res_ok[i]             = slot_ok;
    end

    assign res_valid   = (state == TS_DONE);
    assign res_timeout = timeout_q;
endmodule

// File: rtl/tdc_multistop_chk.sv
// Property checker for tdc_multistop_core, attached by bind. It watches
// only the result interface.
// Assumes: the same parameters as the bound core.
module tdc_multistop_chk #(
    parameter int CNT_W  = 13,
    parameter int MID_W  = 3,
    parameter int FINE_W = 2,
    parameter int N_STOP = 3,
    localparam int TW    = CNT_W + MID_W + FINE_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 res_valid,
    input logic                 res_ready,
    input logic [N_STOP*TW-1:0] res_pos,
    input logic [N_STOP*TW-1:0] res_width,
    input logic [N_STOP-1:0]    res_ok,
    input logic                 res_timeout
);
    localparam logic [N_STOP-1:0] OK_ONE = N_STOP'(1);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_pos) &&
        $stable(res_width) && $stable(res_ok) && $stable(res_timeout));

    // R8
    result_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_ready |=> !res_valid);

    // R4
    all_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_timeout |-> (&res_ok));

    // R6
    timeout_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_timeout |-> !(&res_ok));

    // R4
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_ok & (res_ok + OK_ONE)) == '0));

    for (genvar i = 0; i < N_STOP; i++) begin : g_empty
        // R7
        empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid && !res_ok[i] |->
            (res_pos[i*TW +: TW] == '0) && (res_width[i*TW +: TW] == '0));
    end
endmodule

bind tdc_multistop_core tdc_multistop_chk #(
    .CNT_W(CNT_W), .MID_W(MID_W), .FINE_W(FINE_W), .N_STOP(N_STOP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_pos     (res_pos),
    .res_width   (res_width),
    .res_ok      (res_ok),
    .res_timeout (res_timeout)
);

// File: tb/test_tdc_multistop_core.sv
`timescale 1ns/1ps
module test_tdc_multistop_core;
    localparam int CNT_W  = 8;
    localparam int MID_W  = 3;
    localparam int FINE_W = 2;
    localparam int N_STOP = 3;
    localparam int TW     = CNT_W + MID_W + FINE_W;
    localparam int PER    = 1 << (MID_W + FINE_W);
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int MASK   = (1 << TW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_stb = 1'b0, rise_stb = 1'b0, fall_stb = 1'b0, res_ready = 1'b0;
    logic [MID_W-1:0]  start_mid = '0, rise_mid = '0, fall_mid = '0;
    logic [FINE_W-1:0] start_fine = '0, rise_fine = '0, fall_fine = '0;
    logic                 res_valid, res_timeout;
    logic [N_STOP*TW-1:0] res_pos, res_width;
    logic [N_STOP-1:0]    res_ok;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tdc_multistop_core #(.CNT_W(CNT_W), .MID_W(MID_W), .FINE_W(FINE_W), .N_STOP(N_STOP))
    i_tdc_multistop_core (
        .clk(clk), .rst_n(rst_n),
        .start_stb(start_stb), .start_mid(start_mid), .start_fine(start_fine),
        .rise_stb(rise_stb), .rise_mid(rise_mid), .rise_fine(rise_fine),
        .fall_stb(fall_stb), .fall_mid(fall_mid), .fall_fine(fall_fine),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_pos(res_pos), .res_width(res_width), .res_ok(res_ok),
        .res_timeout(res_timeout)
    );

    // Row fields: 0 start mid, 1 start fine; per pulse p at 2+6p:
    // rise cycle, rise mid, rise fine, fall cycle, fall mid, fall fine;
    // 20 repeated START cycle, 21 stray fall cycle, 22 stray rise cycle (0 = none)
    localparam int NV = 4;
    localparam int NF = 23;
    localparam int TAB [NV][NF] = '{
        '{0,0,   3,0,0,   5,0,0,    8,2,1,  12,5,3,   20,7,3,  21,0,0,   0, 0, 0},
        '{7,3,   1,7,3,   2,7,3,    4,0,0,  40,3,2,   41,1,1,  60,6,0,  10, 0, 0},
        '{3,1,   4,2,2,   9,4,1,   15,1,0,  16,6,3,  100,5,2, 130,2,2,   0, 2, 6},
        '{1,2, 250,3,3, 251,1,0,  252,0,1, 253,7,3,  254,4,3, 255,2,1,   0, 0, 0}
    };

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        start_stb = 1'b0; rise_stb = 1'b0; fall_stb = 1'b0;
        start_mid = '0; start_fine = '0;
        rise_mid = '0; rise_fine = '0; fall_mid = '0; fall_fine = '0;
    endtask

    task automatic accept();
        @(negedge clk) res_ready = 1'b1;
        @(negedge clk) res_ready = 1'b0;
        check("R8 valid low after accept", res_valid, 0);
    endtask

    task automatic run_row(int v);
        int s, last;
        string xt;
        xt = (v == 1) ? "R9" : (v == 2) ? "R5" : (v == 3) ? "R6" : "R2";
        @(negedge clk);
        start_stb = 1'b1; start_mid = MID_W'(TAB[v][0]); start_fine = FINE_W'(TAB[v][1]);
        @(negedge clk);
        last = TAB[v][2 + 6*2 + 3];
        for (int c = 1; c <= last; c++) begin
            quiet();
            for (int p = 0; p < 3; p++) begin
                if (TAB[v][2+6*p] == c) begin
                    rise_stb = 1'b1;
                    rise_mid = MID_W'(TAB[v][3+6*p]); rise_fine = FINE_W'(TAB[v][4+6*p]);
                end
                if (TAB[v][5+6*p] == c) begin
                    fall_stb = 1'b1;
                    fall_mid = MID_W'(TAB[v][6+6*p]); fall_fine = FINE_W'(TAB[v][7+6*p]);
                end
            end
            if (TAB[v][21] == c) begin fall_stb = 1'b1; fall_mid = 3'd7; fall_fine = 2'd3; end
            if (TAB[v][22] == c) begin rise_stb = 1'b1; rise_mid = 3'd6; rise_fine = 2'd1; end
            if (TAB[v][20] == c) start_stb = 1'b1;
            @(negedge clk);
            if (c == last - 1) check({xt, " R4 valid before last fall"}, res_valid, 0);
        end
        quiet();
        s = TAB[v][0] * 4 + TAB[v][1];
        check({xt, " R4 valid"}, res_valid, 1);
        check({xt, " R4 ok bits"}, res_ok, 7);
        check({xt, " R6 timeout flag"}, res_timeout, 0);
        for (int p = 0; p < 3; p++) begin
            int rk, r, fk, f;
            rk = TAB[v][2+6*p];  r = TAB[v][3+6*p] * 4 + TAB[v][4+6*p];
            fk = TAB[v][5+6*p];  f = TAB[v][6+6*p] * 4 + TAB[v][7+6*p];
            check({xt, " R2 position"}, res_pos[p*TW +: TW], (rk*PER + s - r) & MASK);
            check({xt, " R3 width"}, res_width[p*TW +: TW], ((fk - rk)*PER + r - f) & MASK);
        end
    endtask

    // watchdog: a hung run ends as a failed check
    initial begin
        repeat (60000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N_STOP*TW-1:0] snap_pos, snap_wid;
        bit seen;
        quiet();
        repeat (3) @(negedge clk);
        check("R1 valid after reset", res_valid, 0);
        check("R1 timeout after reset", res_timeout, 0);
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < NV; v++) begin
            run_row(v);
            if (v == 0) begin
                snap_pos = res_pos; snap_wid = res_width;
                start_stb = 1'b1; start_mid = 3'd5; start_fine = 2'd2;
                @(negedge clk) quiet();
                repeat (3) @(negedge clk);
                check("R8 valid held", res_valid, 1);
                check("R10 positions unchanged", (res_pos == snap_pos), 1);
                check("R10 widths unchanged", (res_width == snap_wid), 1);
            end
            accept();
        end

        // R10: START in the accept cycle is ignored
        run_row(0);
        @(negedge clk);
        res_ready = 1'b1; start_stb = 1'b1;
        @(negedge clk);
        res_ready = 1'b0; quiet();
        seen = 1'b0;
        repeat (CMAX + 5) begin
            @(negedge clk);
            if (res_valid) seen = 1'b1;
        end
        check("R10 no measurement from accept-cycle START", seen, 0);

        // R6 / R7: timeout with one pulse done and one half pulse
        @(negedge clk) start_stb = 1'b1;
        @(negedge clk);
        for (int c = 1; c <= CMAX; c++) begin
            quiet();
            if (c == 2) rise_stb = 1'b1;
            if (c == 3) fall_stb = 1'b1;
            if (c == 5) begin rise_stb = 1'b1; rise_mid = 3'd1; end
            @(negedge clk);
            if (c == CMAX - 1) check("R6 no result before full count", res_valid, 0);
        end
        quiet();
        check("R6 valid at full count", res_valid, 1);
        check("R6 timeout set", res_timeout, 1);
        check("R7 ok bits", res_ok, 1);
        check("R2 timeout slot0 position", res_pos[0 +: TW], 2*PER);
        check("R3 timeout slot0 width", res_width[0 +: TW], PER);
        check("R7 slot1 position zero", res_pos[TW +: TW], 0);
        check("R7 slot1 width zero", res_width[TW +: TW], 0);
        check("R7 slot2 position zero", res_pos[2*TW +: TW], 0);
        accept();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule